// File: doc/BRIEF.md
# Partial-Width General Register File

This block holds eight 32-bit general registers that can be read and written at word, halfword or byte width. Each access names a register index, a size code and a high-byte bit. A narrow write changes only the lanes it addresses and keeps every other bit of the target register. A narrow read returns the selected slice in the low bits of the read port, with all upper bits zero.

Two combinational read ports and one synchronous write port serve the normal datapath. A separate 64-bit result path loads a fixed pair of registers in one clock: the upper half goes to register 2 and the lower half to register 0. This path serves operations such as a widening multiply. Only the first four registers have byte views. An access that names a slice that does not exist raises an error flag on its port. Such a write leaves the file untouched, and such a read returns zero.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero at the next rising edge.
- R2: Size code 2'b10 (word) reads or writes all 32 bits of any register 0 to 7.
- R3: Size code 2'b01 (halfword) addresses bits 15:0 of any register 0 to 7. A halfword write takes wrData[15:0] and keeps bits 31:16. A halfword read returns the slice zero-extended to 32 bits.
- R4: Size code 2'b00 (byte) with the high bit clear, on registers 0 to 3, addresses bits 7:0. A write takes wrData[7:0] and keeps bits 31:8. A read returns the byte zero-extended.
- R5: Size code 2'b00 with the high bit set, on registers 0 to 3, addresses bits 15:8. A write takes wrData[7:0] into bits 15:8 and keeps bits 31:16 and 7:0. A read returns bits 15:8 in rdData[7:0], with all other bits zero.
- R6: An illegal access raises that port's error flag in the same cycle. An illegal access is a byte access to register 4 to 7 (with either value of the high bit), or size code 2'b11. An illegal write leaves every register unchanged, and an illegal read returns zero. The high bit has no effect for word and halfword sizes.
- R7: Reads are combinational. In a cycle where the write port targets the register being read, the read returns the contents from before that write.
- R8: When wideEn is high, register 2 takes wideData[63:32] and register 0 takes wideData[31:0] at the rising edge.
- R9: If the normal write targets register 0 or 2 in the same cycle as a 64-bit write, the 64-bit write sets that register and the normal write is dropped. A normal write to any other register in that cycle still takes effect.
- R10: The two read ports decode their index, size and high bit independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rdIdxA | input | 3 | Read port A register index |
| rdSizeA | input | 2 | Read port A size code |
| rdHighA | input | 1 | Read port A high-byte select |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdErrA | output | 1 | Read port A illegal access |
| rdIdxB | input | 3 | Read port B register index |
| rdSizeB | input | 2 | Read port B size code |
| rdHighB | input | 1 | Read port B high-byte select |
| rdDataB | output | 32 | Read port B data, zero-extended |
| rdErrB | output | 1 | Read port B illegal access |
| wrEn | input | 1 | Write port enable |
| wrIdx | input | 3 | Write register index |
| wrSize | input | 2 | Write size code |
| wrHigh | input | 1 | Write high-byte select |
| wrData | input | 32 | Write data, right-aligned |
| wrErr | output | 1 | Write port illegal access |
| wideEn | input | 1 | 64-bit result write enable |
| wideData | input | 64 | 64-bit result, upper half to register 2 |

## Verification
The bench targets lane preservation. It writes narrow values into registers that already hold all-ones or mixed patterns. A design with a wrong lane mask would clear or overwrite bits outside the slice, and one that aligned the data badly would put a high-byte write into bits 7:0. It probes the high bit on registers 4 to 7, and on sizes where the bit should not matter. A design that let those accesses through would corrupt the file or show nonzero read data where zero is expected. It also issues a 64-bit write in the same cycle as a normal write to register 0, 2 and another register. A design with the wrong priority would let the narrow write win, or would drop the unrelated write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN  = 32;
  localparam int LANES = XLEN / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrGo;
    logic [LANES-1:0] laneEn;
    logic             laneShift;
    logic             wideGo;
    logic             rdOkA;
    logic             rdOkB;
  } strobe_t;
endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int BYTE_REGS = 4,
  localparam int IDXW     = $clog2(NREG)
) (
  input  logic [IDXW-1:0] rdIdxA,
  input  logic [1:0]      rdSizeA,
  input  logic [IDXW-1:0] rdIdxB,
  input  logic [1:0]      rdSizeB,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [1:0]      wrSize,
  input  logic            wrHigh,
  input  logic            wideEn,
  output strobe_t         str,
  output logic            rdErrA,
  output logic            rdErrB,
  output logic            wrErr
);
  function automatic logic sliceExists(input logic [IDXW-1:0] idx, input logic [1:0] sz);
    case (size_e'(sz))
      SZ_WORD, SZ_HALF: sliceExists = 1'b1;
      SZ_BYTE:          sliceExists = (int'(idx) < BYTE_REGS);
      default:          sliceExists = 1'b0;
    endcase
  endfunction

  logic wrOk;
  logic [LANES-1:0] laneMask;

  always_comb begin
    case (size_e'(wrSize))
      SZ_WORD: laneMask = {LANES{1'b1}};
      SZ_HALF: laneMask = LANES'(2'b11);
      SZ_BYTE: laneMask = wrHigh ? LANES'(2'b10) : LANES'(2'b01);
      default: laneMask = '0;
    endcase
  end

  assign wrOk   = sliceExists(wrIdx, wrSize);
  assign wrErr  = wrEn & ~wrOk;
  assign rdErrA = ~sliceExists(rdIdxA, rdSizeA);
  assign rdErrB = ~sliceExists(rdIdxB, rdSizeB);

  always_comb begin
    str.wrGo      = wrEn & wrOk;
    str.laneEn    = laneMask;
    str.laneShift = (size_e'(wrSize) == SZ_BYTE) & wrHigh;
    str.wideGo    = wideEn;
    str.rdOkA     = ~rdErrA;
    str.rdOkB     = ~rdErrB;
  end
endmodule

// File: rtl/gpr_datapath.sv
module gpr_datapath
  import gpr_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int WIDE_HI = 2,
  parameter int WIDE_LO = 0,
  localparam int IDXW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           str,
  input  logic [IDXW-1:0]   wrIdx,
  input  logic [XLEN-1:0]   wrData,
  input  logic [2*XLEN-1:0] wideData,
  input  logic [IDXW-1:0]   rdIdxA,
  input  logic [1:0]        rdSizeA,
  input  logic              rdHighA,
  input  logic [IDXW-1:0]   rdIdxB,
  input  logic [1:0]        rdSizeB,
  input  logic              rdHighB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  output logic [NREG*XLEN-1:0] snapView
);
  logic [XLEN-1:0] alignedData;
  assign alignedData = str.laneShift ? {{(XLEN-16){1'b0}}, wrData[7:0], 8'h00} : wrData;

  for (genvar g = 0; g < NREG; g++) begin : gReg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (str.wideGo && g == WIDE_HI) begin
        q <= wideData[2*XLEN-1:XLEN];
      end else if (str.wideGo && g == WIDE_LO) begin
        q <= wideData[XLEN-1:0];
      end else if (str.wrGo && int'(wrIdx) == g) begin
        for (int b = 0; b < LANES; b++) begin
          if (str.laneEn[b]) q[8*b +: 8] <= alignedData[8*b +: 8];
        end
      end
    end
    assign snapView[g*XLEN +: XLEN] = q;
  end

  function automatic logic [XLEN-1:0] slice(input logic [XLEN-1:0] w, input logic [1:0] sz,
                                            input logic hi);
    case (size_e'(sz))
      SZ_WORD: slice = w;
      SZ_HALF: slice = {{(XLEN-16){1'b0}}, w[15:0]};
      SZ_BYTE: slice = hi ? {{(XLEN-8){1'b0}}, w[15:8]} : {{(XLEN-8){1'b0}}, w[7:0]};
      default: slice = '0;
    endcase
  endfunction

  logic [XLEN-1:0] wordA, wordB;
  assign wordA   = snapView[XLEN*int'(rdIdxA) +: XLEN];
  assign wordB   = snapView[XLEN*int'(rdIdxB) +: XLEN];
  assign rdDataA = str.rdOkA ? slice(wordA, rdSizeA, rdHighA) : '0;
  assign rdDataB = str.rdOkB ? slice(wordB, rdSizeB, rdHighB) : '0;
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int BYTE_REGS = 4,
  parameter int WIDE_HI   = 2,
  parameter int WIDE_LO   = 0,
  localparam int IDXW     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDXW-1:0]   rdIdxA,
  input  logic [1:0]        rdSizeA,
  input  logic              rdHighA,
  output logic [XLEN-1:0]   rdDataA,
  output logic              rdErrA,
  input  logic [IDXW-1:0]   rdIdxB,
  input  logic [1:0]        rdSizeB,
  input  logic              rdHighB,
  output logic [XLEN-1:0]   rdDataB,
  output logic              rdErrB,
  input  logic              wrEn,
  input  logic [IDXW-1:0]   wrIdx,
  input  logic [1:0]        wrSize,
  input  logic              wrHigh,
  input  logic [XLEN-1:0]   wrData,
  output logic              wrErr,
  input  logic              wideEn,
  input  logic [2*XLEN-1:0] wideData
);
  strobe_t str;
  logic [NREG*XLEN-1:0] snapView;

  gpr_ctrl #(.NREG(NREG), .BYTE_REGS(BYTE_REGS)) u_ctrl (
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdIdxB(rdIdxB), .rdSizeB(rdSizeB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrHigh(wrHigh), .wideEn(wideEn),
    .str(str), .rdErrA(rdErrA), .rdErrB(rdErrB), .wrErr(wrErr)
  );

  gpr_datapath #(.NREG(NREG), .WIDE_HI(WIDE_HI), .WIDE_LO(WIDE_LO)) u_dp (
    .clk(clk), .rst(rst), .str(str), .wrIdx(wrIdx), .wrData(wrData), .wideData(wideData),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdHighA(rdHighA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdHighB(rdHighB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .snapView(snapView)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk #(
  parameter int NREG    = 8,
  parameter int WIDE_HI = 2,
  parameter int WIDE_LO = 0,
  localparam int IDXW   = $clog2(NREG)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           rdSizeA,
  input logic [31:0]          rdDataA,
  input logic                 rdErrA,
  input logic [31:0]          rdDataB,
  input logic                 rdErrB,
  input logic                 wrEn,
  input logic [IDXW-1:0]      wrIdx,
  input logic [1:0]           wrSize,
  input logic                 wrHigh,
  input logic [31:0]          wrData,
  input logic                 wrErr,
  input logic                 wideEn,
  input logic [63:0]          wideData,
  input logic [NREG*32-1:0]   snapView
);
  logic [IDXW-1:0] idxQ;
  logic [31:0] tgtPrev, tgtNow, hiNow, loNow;
  logic collide, goodWr;

  always_ff @(posedge clk) idxQ <= wrIdx;

  assign tgtPrev = snapView[32*int'(wrIdx) +: 32];
  assign tgtNow  = snapView[32*int'(idxQ) +: 32];
  assign hiNow   = snapView[32*WIDE_HI +: 32];
  assign loNow   = snapView[32*WIDE_LO +: 32];
  assign collide = wideEn && (int'(wrIdx) == WIDE_HI || int'(wrIdx) == WIDE_LO);
  assign goodWr  = wrEn && !wrErr && !collide;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> snapView == '0);

  assert_word_write_R2: assert property (@(posedge clk) disable iff (rst)
    goodWr && wrSize == 2'b10 |=> tgtNow == $past(wrData));

  assert_half_keep_R3: assert property (@(posedge clk) disable iff (rst)
    goodWr && wrSize == 2'b01 |=>
      tgtNow[31:16] == $past(tgtPrev[31:16]) && tgtNow[15:0] == $past(wrData[15:0]));

  assert_half_zext_R3: assert property (@(posedge clk) disable iff (rst)
    rdSizeA == 2'b01 |-> rdDataA[31:16] == 16'h0);

  assert_byte_lo_R4: assert property (@(posedge clk) disable iff (rst)
    goodWr && wrSize == 2'b00 && !wrHigh |=>
      tgtNow[31:8] == $past(tgtPrev[31:8]) && tgtNow[7:0] == $past(wrData[7:0]));

  assert_byte_hi_R5: assert property (@(posedge clk) disable iff (rst)
    goodWr && wrSize == 2'b00 && wrHigh |=>
      tgtNow[31:16] == $past(tgtPrev[31:16]) && tgtNow[7:0] == $past(tgtPrev[7:0]) &&
      tgtNow[15:8] == $past(wrData[7:0]));

  assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (rst)
    wrErr && !wideEn |=> $stable(snapView));

  assert_illegal_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rdErrA |-> rdDataA == 32'h0) and (rdErrB |-> rdDataB == 32'h0));

  assert_err_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    wrErr |-> wrEn);

  assert_wide_pair_R8: assert property (@(posedge clk) disable iff (rst)
    wideEn |=> hiNow == $past(wideData[63:32]) && loNow == $past(wideData[31:0]));
endmodule

bind gpr_file gpr_file_chk #(.NREG(NREG), .WIDE_HI(WIDE_HI), .WIDE_LO(WIDE_LO)) u_chk (
  .clk(clk), .rst(rst), .rdSizeA(rdSizeA), .rdDataA(rdDataA), .rdErrA(rdErrA),
  .rdDataB(rdDataB), .rdErrB(rdErrB), .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize),
  .wrHigh(wrHigh), .wrData(wrData), .wrErr(wrErr), .wideEn(wideEn), .wideData(wideData),
  .snapView(snapView)
);

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
  logic clk = 1'b0;
  logic rst;
  logic [2:0] rdIdxA, rdIdxB, wrIdx;
  logic [1:0] rdSizeA, rdSizeB, wrSize;
  logic rdHighA, rdHighB, wrHigh, wrEn, wideEn;
  logic [31:0] wrData, rdDataA, rdDataB;
  logic [63:0] wideData;
  logic rdErrA, rdErrB, wrErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] mdl [8];

  always #2 clk = ~clk;

  gpr_file u_dut (
    .clk(clk), .rst(rst),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdHighA(rdHighA), .rdDataA(rdDataA), .rdErrA(rdErrA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdHighB(rdHighB), .rdDataB(rdDataB), .rdErrB(rdErrB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrHigh(wrHigh), .wrData(wrData), .wrErr(wrErr),
    .wideEn(wideEn), .wideData(wideData)
  );

  function automatic bit legal(input int idx, input int sz);
    return sz == 2 || sz == 1 || (sz == 0 && idx < 4);
  endfunction

  function automatic logic [31:0] expRead(input int idx, input int sz, input bit hi);
    logic [31:0] w;
    w = mdl[idx];
    if (!legal(idx, sz)) return 32'h0;
    if (sz == 2) return w;
    if (sz == 1) return {16'h0, w[15:0]};
    return hi ? {24'h0, w[15:8]} : {24'h0, w[7:0]};
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // One clock: drive after negedge, check combinational outputs, then update the model
  task automatic step(input string tag,
                      input int ai, input int as, input bit ah,
                      input int bi, input int bs, input bit bh,
                      input bit we, input int wi, input int ws, input bit wh,
                      input logic [31:0] wd, input bit wde, input logic [63:0] wdd);
    @(negedge clk);
    rdIdxA = 3'(ai); rdSizeA = 2'(as); rdHighA = ah;
    rdIdxB = 3'(bi); rdSizeB = 2'(bs); rdHighB = bh;
    wrEn = we; wrIdx = 3'(wi); wrSize = 2'(ws); wrHigh = wh; wrData = wd;
    wideEn = wde; wideData = wdd;
    #1;
    check(tag, "rdDataA", 64'(rdDataA), 64'(expRead(ai, as, ah)));
    check(tag, "rdErrA",  64'(rdErrA),  64'(!legal(ai, as)));
    check(tag, "rdDataB", 64'(rdDataB), 64'(expRead(bi, bs, bh)));
    check(tag, "rdErrB",  64'(rdErrB),  64'(!legal(bi, bs)));
    check(tag, "wrErr",   64'(wrErr),   64'(we && !legal(wi, ws)));
    @(posedge clk);
    if (rst) begin
      for (int r = 0; r < 8; r++) mdl[r] = 32'h0;
    end else begin
      if (we && legal(wi, ws) && !(wde && (wi == 0 || wi == 2))) begin
        if (ws == 2) mdl[wi] = wd;
        else if (ws == 1) mdl[wi][15:0] = wd[15:0];
        else if (wh) mdl[wi][15:8] = wd[7:0];
        else mdl[wi][7:0] = wd[7:0];
      end
      if (wde) begin
        mdl[2] = wdd[63:32];
        mdl[0] = wdd[31:0];
      end
    end
  endtask

  task automatic wr(input string tag, input int wi, input int ws, input bit wh,
                    input logic [31:0] wd);
    step(tag, wi, 2, 0, wi, ws, wh, 1, wi, ws, wh, wd, 0, 64'h0);
  endtask

  task automatic rdWord(input string tag, input int i);
    step(tag, i, 2, 0, i, 2, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) mdl[r] = 32'hDEADBEEF;
    rst = 1'b1;
    // Dirty the file during reset cycles to prove reset wins
    step("R1", 0, 3, 0, 0, 3, 0, 1, 3, 2, 0, 32'hFFFFFFFF, 1, 64'hFFFFFFFF_FFFFFFFF);
    step("R1", 0, 3, 0, 0, 3, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
    rst = 1'b0;
    for (int r = 0; r < 8; r++) rdWord("R1", r);

    // R2 word write and read, every register
    for (int r = 0; r < 8; r++) wr("R2", r, 2, 0, 32'h1111_1111 * (r + 1));
    for (int r = 0; r < 8; r++) rdWord("R2", r);

    // R3 halfword on a high register, with high bit set (ignored)
    wr("R3", 5, 2, 0, 32'h12345678);
    wr("R3", 5, 1, 1, 32'hFFFFAAAA);
    step("R3", 5, 1, 0, 5, 2, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
    step("R3", 5, 1, 1, 5, 2, 1, 0, 0, 2, 0, 32'h0, 0, 64'h0);

    // R4 low byte, R5 high byte, on all-ones background
    wr("R4", 1, 2, 0, 32'hFFFFFFFF);
    wr("R4", 1, 0, 0, 32'hFFFF005A);
    rdWord("R4", 1);
    step("R4", 1, 0, 0, 1, 1, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
    wr("R5", 1, 0, 1, 32'h000000C3);
    rdWord("R5", 1);
    step("R5", 1, 0, 1, 1, 0, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
    wr("R5", 3, 2, 0, 32'h00000000);
    wr("R5", 3, 0, 1, 32'hFFFFFF81);
    step("R5", 3, 2, 0, 3, 0, 1, 0, 0, 2, 0, 32'h0, 0, 64'h0);

    // R6 illegal byte accesses on registers 4..7, and reserved size
    for (int r = 4; r < 8; r++) begin
      wr("R6", r, 0, r[0], 32'h000000EE);
      step("R6", r, 0, 0, r, 0, 1, 0, 0, 2, 0, 32'h0, 0, 64'h0);
      rdWord("R6", r);
    end
    wr("R6", 2, 3, 0, 32'hCAFEF00D);
    rdWord("R6", 2);

    // R7 read during write to same register returns old value
    wr("R7", 6, 2, 0, 32'hA5A5A5A5);
    step("R7", 6, 2, 0, 6, 1, 0, 1, 6, 2, 0, 32'h5A5A5A5A, 0, 64'h0);
    rdWord("R7", 6);

    // R8 wide write
    step("R8", 0, 2, 0, 2, 2, 0, 0, 0, 2, 0, 32'h0, 1, 64'h89ABCDEF_01234567);
    step("R8", 0, 2, 0, 2, 2, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);

    // R9 collisions: wide beats a write to 0 and to 2, not to 4
    step("R9", 0, 2, 0, 2, 2, 0, 1, 0, 2, 0, 32'h77777777, 1, 64'h22222222_00000000);
    step("R9", 0, 2, 0, 2, 2, 0, 1, 2, 0, 1, 32'h000000FF, 1, 64'h33333333_44444444);
    step("R9", 0, 2, 0, 2, 2, 0, 1, 4, 1, 0, 32'h0000BEEF, 1, 64'h55555555_66666666);
    step("R9", 4, 2, 0, 2, 2, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);
    step("R9", 0, 2, 0, 2, 2, 0, 0, 0, 2, 0, 32'h0, 0, 64'h0);

    // R10 independent ports under mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rA, rB, rW;
      rA = $urandom; rB = $urandom; rW = $urandom;
      step("R10", int'(rA[2:0]), int'(rA[4:3]), rA[5],
           int'(rB[2:0]), int'(rB[4:3]), rB[5],
           rW[0], int'(rW[3:1]), int'(rW[5:4]), rW[6], $urandom,
           (rW[11:8] == 4'h0), {$urandom, $urandom});
    end
    for (int r = 0; r < 8; r++) rdWord("R10", r);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule